// File: doc/BRIEF.md
# Reset and Wake-up Sequencer

This block produces the internal chip reset. It merges the two reset sources, the external reset pin and the watchdog request, and keeps the internal reset asserted until every start-up condition holds. The pin is synchronised and then filtered, so short glitches are ignored. A watchdog request is latched, so even a single-cycle pulse starts a complete sequence. The internal reset is released only when all of the following are true: no source is active, the oscillator reports that it is running, a fixed number of clock cycles has elapsed while the oscillator was running, and the flash controller reports that its initialisation is finished.

A two-bit cause register records which source started the most recent sequence. It can be read once the chip leaves reset. A power-on reset input initialises the sequencer. Power-on reset asserts the internal reset at once, without waiting for a clock edge. Release is always synchronous to the clock.

Top module: `wakeup_reset_seq`

## Requirements
- R1: While `por_n` is low, `sys_rst_n` is low and `rst_cause` is 2'b00. A falling `por_n` drives `sys_rst_n` low with no clock edge.
- R2: A low pulse on `ext_rst_n` that lasts fewer than FILT_LEN clock cycles has no effect on `sys_rst_n` or `rst_cause`.
- R3: A low level on `ext_rst_n` that lasts at least FILT_LEN cycles asserts `sys_rst_n`. The reset stays asserted while the pin stays low, and `rst_cause` bit 0 (pin) is set.
- R4: A high `wdog_req` drives `sys_rst_n` low in the same cycle. A one-cycle pulse starts a complete wake-up sequence and sets `rst_cause` bit 1 (watchdog).
- R5: When both sources are active within one hold period, `rst_cause` reads 2'b11. A new sequence started from the released state overwrites the previous cause.
- R6: `sys_rst_n` stays low for as long as `osc_running` is low.
- R7: When all sources are quiet and the oscillator is running, the release comes WAKE_CYCLES+2 clock edges after the sequencer enters its wait-for-oscillator state, for example after `por_n` rises.
- R8: `sys_rst_n` stays low until `flash_init_done` is high. If the count has already finished, the release comes one edge after `flash_init_done` rises.
- R9: A source that reasserts during the count restarts the count from zero.
- R10: `sys_rst_n` rises only on a clock edge, and `rst_cause` does not change while `sys_rst_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous to clk |
| wdog_req | input | 1 | Watchdog reset request, active high |
| osc_running | input | 1 | Oscillator is running |
| flash_init_done | input | 1 | Flash controller initialisation is complete |
| sys_rst_n | output | 1 | Internal chip reset, active low |
| rst_cause | output | 2 | Bit 0: the pin started the last sequence. Bit 1: the watchdog started it. |

## Verification
The bench builds the block with WAKE_CYCLES set to 16 and FILT_LEN kept at 4. With this short count, the exact release edge, the restart of the count in the middle of a sequence and the flash gating all happen within a few dozen cycles, so the bench can check each of them exactly. Keeping the filter at its default depth lets a table of pin pulse lengths lie on both sides of the acceptance threshold. The boundary cases are three cycles, which must be ignored, and four cycles, which must cause a reset.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
   typedef enum logic [2:0] {
      ST_HOLD,
      ST_WAIT_OSC,
      ST_COUNT,
      ST_WAIT_FLASH,
      ST_RUN
   } seq_state_t;

   localparam int CAUSE_W   = 2;
   localparam int CAUSE_PIN = 0;
   localparam int CAUSE_WDG = 1;
endpackage

// File: rtl/rsq_pin_filter.sv
module rsq_pin_filter #(
   parameter int FILT_LEN = 4
) (
   input  logic clk,
   input  logic arst_n,
   input  logic pin_n,
   output logic pin_act
);
   localparam int FW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

   logic s1, s2, lvl;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         s1 <= 1'b1;
         s2 <= 1'b1;
      end else begin
         s1 <= pin_n;
         s2 <= s1;
      end
   end

   generate
      if (FILT_LEN == 1) begin : g_direct
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) lvl <= 1'b1;
            else         lvl <= s2;
         end
      end else begin : g_counted
         logic [FW-1:0] run_len;
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) begin
               lvl     <= 1'b1;
               run_len <= '0;
            end else if (s2 == lvl) begin
               run_len <= '0;
            end else if (run_len == FW'(FILT_LEN - 1)) begin
               lvl     <= s2;
               run_len <= '0;
            end else begin
               run_len <= run_len + 1'b1;
            end
         end
      end
   endgenerate

   assign pin_act = ~lvl;
endmodule

// File: rtl/rsq_wake_timer.sv
module rsq_wake_timer #(
   parameter int WAKE_CYCLES = 4096
) (
   input  logic clk,
   input  logic arst_n,
   input  logic run,
   output logic done
);
   localparam int CW = $clog2(WAKE_CYCLES);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)   cnt <= '0;
      else if (!run) cnt <= '0;
      else if (!done) cnt <= cnt + 1'b1;
   end

   assign done = run && (cnt == CW'(WAKE_CYCLES - 1));
endmodule

// File: rtl/rsq_cause_reg.sv
module rsq_cause_reg
   import rsq_pkg::*;
(
   input  logic               clk,
   input  logic               arst_n,
   input  logic               capture,
   input  logic               merge,
   input  logic               pin_src,
   input  logic               wdg_src,
   output logic [CAUSE_W-1:0] cause
);
   logic [CAUSE_W-1:0] now_bits;

   always_comb begin
      now_bits            = '0;
      now_bits[CAUSE_PIN] = pin_src;
      now_bits[CAUSE_WDG] = wdg_src;
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)      cause <= '0;
      else if (capture) cause <= now_bits;
      else if (merge)   cause <= cause | now_bits;
   end
endmodule

// File: rtl/wakeup_reset_seq.sv
module wakeup_reset_seq
   import rsq_pkg::*;
#(
   parameter int WAKE_CYCLES = 4096,
   parameter int FILT_LEN    = 4
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       ext_rst_n,
   input  logic       wdog_req,
   input  logic       osc_running,
   input  logic       flash_init_done,
   output logic       sys_rst_n,
   output logic [1:0] rst_cause
);
   generate
      if (WAKE_CYCLES < 2) begin : g_bad_wake
         $error("WAKE_CYCLES must be at least 2");
      end
      if (FILT_LEN < 1) begin : g_bad_filt
         $error("FILT_LEN must be at least 1");
      end
   endgenerate

   seq_state_t state, nxt;
   logic pin_act, wd_lat, wdg_src, src_act, cnt_done;

   rsq_pin_filter #(.FILT_LEN(FILT_LEN)) i_filt (
      .clk(clk), .arst_n(por_n), .pin_n(ext_rst_n), .pin_act(pin_act));

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                  wd_lat <= 1'b0;
      else if (wdog_req)           wd_lat <= 1'b1;
      else if (state == ST_HOLD)   wd_lat <= 1'b0;
   end

   assign wdg_src = wdog_req | wd_lat;
   assign src_act = pin_act | wdg_src;

   rsq_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) i_timer (
      .clk(clk), .arst_n(por_n), .run(state == ST_COUNT), .done(cnt_done));

   always_comb begin
      nxt = state;
      if (src_act) nxt = ST_HOLD;
      else begin
         case (state)
            ST_HOLD:       nxt = ST_WAIT_OSC;
            ST_WAIT_OSC:   if (osc_running) nxt = ST_COUNT;
            ST_COUNT:      if (!osc_running) nxt = ST_WAIT_OSC;
                           else if (cnt_done) nxt = ST_WAIT_FLASH;
            ST_WAIT_FLASH: if (!osc_running) nxt = ST_WAIT_OSC;
                           else if (flash_init_done) nxt = ST_RUN;
            ST_RUN:        nxt = ST_RUN;
            default:       nxt = ST_HOLD;
         endcase
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) state <= ST_WAIT_OSC;
      else        state <= nxt;
   end

   rsq_cause_reg i_cause (
      .clk(clk), .arst_n(por_n),
      .capture(src_act && state != ST_HOLD),
      .merge(src_act && state == ST_HOLD),
      .pin_src(pin_act), .wdg_src(wdg_src), .cause(rst_cause));

   assign sys_rst_n = (state == ST_RUN) && !src_act;
endmodule

// File: rtl/wakeup_reset_seq_chk.sv
module wakeup_reset_seq_chk #(
   parameter int WAKE_CYCLES = 4096
) (
   input logic       clk,
   input logic       por_n,
   input logic       wdog_req,
   input logic       osc_running,
   input logic       flash_init_done,
   input logic       sys_rst_n,
   input logic [1:0] rst_cause
);
   localparam int QW = $clog2(WAKE_CYCLES + 1);
   logic [QW-1:0] quiet;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) quiet <= '0;
      else if (!osc_running || wdog_req) quiet <= '0;
      else if (quiet != QW'(WAKE_CYCLES)) quiet <= quiet + 1'b1;
   end

   // R4
   wdog_holds_chk: assert property (@(posedge clk) disable iff (!por_n)
      wdog_req |-> !sys_rst_n);

   // R8
   flash_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
      $rose(sys_rst_n) |-> $past(flash_init_done));

   // R7
   wake_count_chk: assert property (@(posedge clk) disable iff (!por_n)
      $rose(sys_rst_n) |-> quiet == QW'(WAKE_CYCLES));

   // R10
   cause_stable_chk: assert property (@(posedge clk) disable iff (!por_n)
      (sys_rst_n && $past(sys_rst_n)) |-> $stable(rst_cause));

   // R6
   osc_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
      !osc_running |-> !sys_rst_n);
endmodule

bind wakeup_reset_seq wakeup_reset_seq_chk #(.WAKE_CYCLES(WAKE_CYCLES)) i_chk (
   .clk(clk), .por_n(por_n), .wdog_req(wdog_req), .osc_running(osc_running),
   .flash_init_done(flash_init_done), .sys_rst_n(sys_rst_n), .rst_cause(rst_cause));

// File: tb/test_wakeup_reset_seq.sv
module test_wakeup_reset_seq;
   localparam int W = 16;
   localparam int F = 4;
   localparam int NV = 6;
   localparam int GL_LEN [NV] = '{1, 2, 3, 4, 5, 9};
   localparam bit GL_RST [NV] = '{0, 0, 0, 1, 1, 1};

   logic clk = 0;
   logic por_n = 0, ext_rst_n = 1, wdog_req = 0, osc_running = 1, flash_init_done = 1;
   logic sys_rst_n;
   logic [1:0] rst_cause;
   int total = 0, bad = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   wakeup_reset_seq #(.WAKE_CYCLES(W), .FILT_LEN(F)) i_wakeup_reset_seq (
      .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .wdog_req(wdog_req),
      .osc_running(osc_running), .flash_init_done(flash_init_done),
      .sys_rst_n(sys_rst_n), .rst_cause(rst_cause));

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_rel(output int n);
      n = 0;
      while (!sys_rst_n && n < 1000) begin
         tick();
         n++;
      end
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=0 expected=1");
         finish_run();
      end
   end

   initial begin
      int n, n2, prev;
      bit saw;
      @(negedge clk);
      tick();
      // R1: reset state during power-on
      chk("R1 rst low", sys_rst_n, 0);
      chk("R1 cause", rst_cause, 0);
      por_n = 1;
      // R7: exact release edge after power-on
      wait_rel(n);
      chk("R7 release edges", n, W + 2);
      chk("R1 cause after release", rst_cause, 0);

      // R2 R3: vector table of pin pulse lengths
      for (int v = 0; v < NV; v++) begin
         prev = rst_cause;
         ext_rst_n = 0;
         repeat (GL_LEN[v]) tick();
         ext_rst_n = 1;
         saw = 0;
         for (int k = 0; k < 10; k++) begin
            if (!sys_rst_n) saw = 1;
            tick();
         end
         chk(GL_RST[v] ? "R3 pulse accepted" : "R2 pulse ignored", saw, GL_RST[v]);
         if (GL_RST[v]) begin
            wait_rel(n);
            chk("R3 cause pin", rst_cause, 1);
         end else begin
            chk("R2 cause unchanged", rst_cause, prev);
         end
      end

      // R3: reset held while pin stays low
      ext_rst_n = 0;
      repeat (8) tick();
      saw = 0;
      for (int k = 0; k < 60; k++) begin
         if (sys_rst_n) saw = 1;
         tick();
      end
      chk("R3 held while pin low", saw, 0);
      ext_rst_n = 1;
      wait_rel(n);
      chk("R3 released", sys_rst_n, 1);

      // R4: one-cycle watchdog pulse
      wdog_req = 1;
      #1;
      chk("R4 same-cycle assert", sys_rst_n, 0);
      tick();
      wdog_req = 0;
      wait_rel(n);
      chk("R4 full sequence", (n >= W + 2 && n <= W + 6), 1);
      chk("R4 cause wdog", rst_cause, 2);

      // R5: both sources in one hold period
      ext_rst_n = 0;
      repeat (8) tick();
      wdog_req = 1;
      tick();
      wdog_req = 0;
      tick();
      ext_rst_n = 1;
      wait_rel(n);
      chk("R5 cause both", rst_cause, 3);
      // R5: fresh sequence overwrites cause
      wdog_req = 1;
      tick();
      wdog_req = 0;
      wait_rel(n);
      chk("R5 cause overwritten", rst_cause, 2);

      // R9: watchdog during count restarts it
      wdog_req = 1;
      tick();
      wdog_req = 0;
      repeat (W / 2 + 4) tick();
      chk("R9 still in reset mid count", sys_rst_n, 0);
      wdog_req = 1;
      tick();
      wdog_req = 0;
      wait_rel(n2);
      chk("R9 count restarted", (n2 >= W + 2 && n2 <= W + 6), 1);

      // R6: oscillator not running holds reset
      osc_running = 0;
      wdog_req = 1;
      tick();
      wdog_req = 0;
      saw = 0;
      for (int k = 0; k < 100; k++) begin
         if (sys_rst_n) saw = 1;
         tick();
      end
      chk("R6 held without osc", saw, 0);
      osc_running = 1;
      wait_rel(n);
      chk("R6 release after osc", n, W + 2);

      // R8: flash gating
      flash_init_done = 0;
      wdog_req = 1;
      tick();
      wdog_req = 0;
      repeat (W + 20) tick();
      chk("R8 held without flash", sys_rst_n, 0);
      flash_init_done = 1;
      tick();
      chk("R8 release one edge after flash", sys_rst_n, 1);

      // R10: cause stable while released
      prev = rst_cause;
      repeat (20) tick();
      chk("R10 cause stable", rst_cause, prev);
      chk("R10 still released", sys_rst_n, 1);

      // R1: asynchronous assertion by power-on reset
      #1;
      por_n = 0;
      #1;
      chk("R1 async assert", sys_rst_n, 0);
      chk("R1 cause cleared", rst_cause, 0);
      @(negedge clk);
      por_n = 1;
      wait_rel(n);
      chk("R7 release after second por", n, W + 2);

      finished = 1;
      finish_run();
   end
endmodule